// File: doc/BRIEF.md
# Hint-Programmed Branch Target Register Predictor

This block is a tiny, fully associative store of branch target registers that sits next to the fetch address generator. It predicts branches the compiler has marked as critical, such as numeric loop branches. Software hint operations load it. A hint is written only when its importance flag is set. Hints without the flag leave the block untouched.

Every fetch cycle the fetch address is compared with all stored branch addresses at once. A match always means "taken". The stored target comes out combinationally in the same cycle, so the fetch unit can redirect without a bubble. Each entry holds a valid bit, a branch address and a target.

When a hint carries a branch address that is already stored, only that entry's target is rewritten. New addresses fill empty entries first, lowest index first. Once the table is full, entries are replaced in round-robin order, oldest write first. A synchronous flush empties the table.

Top module: `tgt_reg_predictor`

## Requirements
- R1: After reset deassertion, no fetch address produces a hit (`pred_taken` = 0, `pred_tgt` = 0).
- R2: A hint with `hint_vld` = 1 and `hint_imp` = 1 stores its branch address and target. From the next cycle on, a lookup of that address gives `pred_taken` = 1 and `pred_tgt` equal to the hinted target.
- R3: A hint with `hint_imp` = 0 has no effect. A lookup of its address misses, and targets stored earlier are unchanged.
- R4: Prediction is combinational from `fetch_addr` with no register on the path. A hit gives `pred_taken` = 1 with the entry's target in the same cycle. A miss gives `pred_taken` = 0 and `pred_tgt` = 0.
- R5: An important hint whose branch address is already stored rewrites only that entry's target and allocates no new entry.
- R6: The table holds `NUM_ENT` entries (default 4). A new address is placed in the lowest-index empty entry while one exists.
- R7: When all entries are valid, each new address replaces entries in round-robin order starting from index 0 after reset or flush. This evicts the least recently allocated entry.
- R8: `flush` = 1 empties the table at the next edge and restarts the replacement order. A hint in the same cycle is discarded.
- R9: A hint becomes visible to lookups in the cycle after it is applied. A lookup in the same cycle sees the previous contents.
- R10: At most one entry matches any address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Synchronous clear of all entries |
| hint_vld | input | 1 | Hint write request |
| hint_imp | input | 1 | Importance flag of the hint; only set hints are written |
| hint_br_addr | input | ADDR_W | Branch address carried by the hint |
| hint_tgt | input | ADDR_W | Target address carried by the hint |
| fetch_addr | input | ADDR_W | Fetch address looked up this cycle |
| pred_taken | output | 1 | Hit: predicted taken |
| pred_tgt | output | ADDR_W | Redirect target on a hit, zero otherwise |

## Verification
Directed sequences cover the following cases:
- Lookups right after reset.
- Allocation followed by a lookup, separately from a lookup in the same cycle as the hint, which shows registered write versus combinational read.
- Unflagged hints to fresh and to stored addresses, which shows "ignored" versus "updated".
- Rewriting a stored address on a full table, which shows in-place update versus eviction.
- A run of replacements, which exposes the round-robin order.
- A flush together with a hint.

Random traffic then draws addresses from a pool of eight, twice the capacity. This gives a steady mix of hits, misses, updates, evictions and occasional flushes, all compared against a reference model in the bench.

// File: rtl/tgtp_pkg.sv
`timescale 1ns/1ps
// Package: shared defaults and helpers for the target register predictor.
// Assumes: entry counts are at least 1.
package tgtp_pkg;
    localparam int DEF_NUM_ENT = 4;
    localparam int DEF_ADDR_W  = 32;

    // Width of an index that selects one of n entries (at least one bit).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/tgtp_entry.sv
`timescale 1ns/1ps
// Module: one target register entry (valid, branch address, target).
// Compares its branch address with the fetch address and with the hint address.
// Assumes: alloc and upd are never both set for the same entry.
module tgtp_entry #(
    parameter int ADDR_W = tgtp_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              alloc,
    input  logic              upd,
    input  logic [ADDR_W-1:0] wr_br,
    input  logic [ADDR_W-1:0] wr_tgt,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              valid,
    output logic              lk_hit,
    output logic              wr_hit,
    output logic [ADDR_W-1:0] tgt
);
    logic [ADDR_W-1:0] br_q;

    // Holds the entry state; clear wins, then allocation, then target update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            br_q  <= '0;
            tgt   <= '0;
        end else if (clr) begin
            valid <= 1'b0;
        end else if (alloc) begin
            valid <= 1'b1;
            br_q  <= wr_br;
            tgt   <= wr_tgt;
        end else if (upd) begin
            tgt   <= wr_tgt;
        end
    end

    // Match against the fetch lookup and against the incoming hint.
    always_comb begin
        lk_hit = valid && (br_q == lk_addr);
        wr_hit = valid && (br_q == wr_br);
    end
endmodule

// File: rtl/tgtp_alloc.sv
`timescale 1ns/1ps
// Module: victim selection for new allocations.
// Picks the lowest empty entry. When none is empty it uses a round-robin
// pointer that advances on each replacement. Flush restarts the pointer.
// Assumes: alloc_req is already qualified by flush in the parent.
module tgtp_alloc #(
    parameter int NUM_ENT = tgtp_pkg::DEF_NUM_ENT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               alloc_req,
    input  logic [NUM_ENT-1:0] valid_vec,
    output logic [NUM_ENT-1:0] victim_oh
);
    localparam int PTR_W = tgtp_pkg::idx_width(NUM_ENT);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_ENT - 1);

    logic [PTR_W-1:0] rr_ptr;
    logic             full;

    // Chooses the first empty slot, else the round-robin slot.
    always_comb begin
        logic found;
        found     = 1'b0;
        victim_oh = '0;
        full      = &valid_vec;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (!valid_vec[i] && !found) begin
                victim_oh[i] = 1'b1;
                found        = 1'b1;
            end
        end
        if (!found) victim_oh[rr_ptr] = 1'b1;
    end

    // Advances the replacement pointer on each eviction; restarts on flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rr_ptr <= '0;
        end else if (alloc_req && full) begin
            rr_ptr <= (rr_ptr == PTR_LAST) ? '0 : rr_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/tgt_reg_predictor.sv
`timescale 1ns/1ps
// Module: hint-programmed branch target register predictor (top).
// An important hint either updates a stored address or allocates a victim.
// A lookup hit gives taken plus the target in the same cycle.
// Assumes: hints write at the clock edge and lookups read the current contents.
module tgt_reg_predictor #(
    parameter int NUM_ENT = tgtp_pkg::DEF_NUM_ENT,
    parameter int ADDR_W  = tgtp_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              hint_vld,
    input  logic              hint_imp,
    input  logic [ADDR_W-1:0] hint_br_addr,
    input  logic [ADDR_W-1:0] hint_tgt,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_tgt
);
    logic [NUM_ENT-1:0] valid_vec;
    logic [NUM_ENT-1:0] hit_vec;
    logic [NUM_ENT-1:0] hint_match;
    logic [NUM_ENT-1:0] victim_oh;
    logic [ADDR_W-1:0]  ent_tgt [NUM_ENT];
    logic               hint_go;
    logic               alloc_req;

    // Qualifies the hint: the importance flag is needed, and flush discards it.
    always_comb begin
        hint_go   = hint_vld && hint_imp && !flush;
        alloc_req = hint_go && (hint_match == '0);
    end

    tgtp_alloc #(.NUM_ENT(NUM_ENT)) u_alloc (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .alloc_req (alloc_req),
        .valid_vec (valid_vec),
        .victim_oh (victim_oh)
    );

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        tgtp_entry #(.ADDR_W(ADDR_W)) u_ent (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (flush),
            .alloc   (alloc_req && victim_oh[g]),
            .upd     (hint_go && hint_match[g]),
            .wr_br   (hint_br_addr),
            .wr_tgt  (hint_tgt),
            .lk_addr (fetch_addr),
            .valid   (valid_vec[g]),
            .lk_hit  (hit_vec[g]),
            .wr_hit  (hint_match[g]),
            .tgt     (ent_tgt[g])
        );
    end

    // Merges the matching entry's target into the redirect output (AND-OR).
    always_comb begin
        pred_tgt = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            pred_tgt = pred_tgt | (ent_tgt[i] & {ADDR_W{hit_vec[i]}});
        end
        pred_taken = |hit_vec;
    end
endmodule

// File: rtl/tgtp_chk.sv
`timescale 1ns/1ps
// Module: property checker for the target register predictor, bound to the top.
// Assumes: observes top-level ports and the per-entry valid and match vectors.
module tgtp_chk #(
    parameter int NUM_ENT = 4,
    parameter int ADDR_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush,
    input logic               hint_vld,
    input logic               hint_imp,
    input logic [NUM_ENT-1:0] valid_vec,
    input logic [NUM_ENT-1:0] hit_vec,
    input logic [NUM_ENT-1:0] hint_match,
    input logic               pred_taken,
    input logic [ADDR_W-1:0]  pred_tgt
);
    // R4
    miss_zero_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken |-> (pred_tgt == '0));

    // R10
    single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec) && $onehot0(hint_match));

    // R8
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0));

    // R3
    unflagged_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hint_vld && !hint_imp && !flush) |=> (valid_vec == $past(valid_vec)));

    // R5
    update_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hint_vld && hint_imp && !flush && (hint_match != '0)) |=> (valid_vec == $past(valid_vec)));

    // R6
    fill_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hint_vld && hint_imp && !flush && (hint_match == '0) && !(&valid_vec))
        |=> ($countones(valid_vec) == $countones($past(valid_vec)) + 1));

    // R7
    replace_stays_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hint_vld && hint_imp && !flush && (&valid_vec)) |=> (&valid_vec));
endmodule

bind tgt_reg_predictor tgtp_chk #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .hint_vld   (hint_vld),
    .hint_imp   (hint_imp),
    .valid_vec  (valid_vec),
    .hit_vec    (hit_vec),
    .hint_match (hint_match),
    .pred_taken (pred_taken),
    .pred_tgt   (pred_tgt)
);

// File: tb/tb_tgt_reg_predictor.sv
`timescale 1ns/1ps
// Bench: directed corner cases, then seeded random traffic.
// Every cycle's lookup is compared against a reference model.
module tb_tgt_reg_predictor;
    localparam int N  = 4;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          hint_vld = 1'b0;
    logic          hint_imp = 1'b0;
    logic [AW-1:0] hint_br_addr = '0;
    logic [AW-1:0] hint_tgt = '0;
    logic [AW-1:0] fetch_addr = '0;
    logic          pred_taken;
    logic [AW-1:0] pred_tgt;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model state
    bit            m_vld [N];
    logic [AW-1:0] m_br  [N];
    logic [AW-1:0] m_tg  [N];
    int            m_ptr;

    tgt_reg_predictor #(.NUM_ENT(N), .ADDR_W(AW)) dut (
        .clk (clk), .rst_n (rst_n), .flush (flush),
        .hint_vld (hint_vld), .hint_imp (hint_imp),
        .hint_br_addr (hint_br_addr), .hint_tgt (hint_tgt),
        .fetch_addr (fetch_addr), .pred_taken (pred_taken), .pred_tgt (pred_tgt)
    );

    always #4 clk = ~clk;   // 125 MHz

    function automatic logic [AW:0] model_lookup(input logic [AW-1:0] a);
        for (int i = 0; i < N; i++)
            if (m_vld[i] && m_br[i] == a) return {1'b1, m_tg[i]};
        return '0;
    endfunction

    function automatic void model_clear();
        for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
        m_ptr = 0;
    endfunction

    function automatic void model_step(input bit hv, input bit hi, input logic [AW-1:0] ha,
                                       input logic [AW-1:0] ht, input bit fl);
        int slot;
        if (fl) begin model_clear(); return; end
        if (!(hv && hi)) return;
        for (int i = 0; i < N; i++)
            if (m_vld[i] && m_br[i] == ha) begin m_tg[i] = ht; return; end
        slot = -1;
        for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) slot = i;
        if (slot < 0) begin slot = m_ptr; m_ptr = (m_ptr + 1) % N; end
        m_vld[slot] = 1'b1; m_br[slot] = ha; m_tg[slot] = ht;
    endfunction

    // One cycle: drive at negedge, check lookup before the edge, then update the model.
    task automatic cyc(input bit hv, input bit hi, input logic [AW-1:0] ha, input logic [AW-1:0] ht,
                       input bit fl, input logic [AW-1:0] fa, input string req);
        logic [AW:0] exp;
        @(negedge clk);
        hint_vld = hv; hint_imp = hi; hint_br_addr = ha; hint_tgt = ht; flush = fl; fetch_addr = fa;
        #1;
        exp = model_lookup(fa);
        n_chk++;
        if (pred_taken !== exp[AW] || pred_tgt !== exp[AW-1:0]) begin
            n_bad++;
            $display("FAIL %s addr=%h actual taken=%b tgt=%h expected taken=%b tgt=%h",
                     req, fa, pred_taken, pred_tgt, exp[AW], exp[AW-1:0]);
        end
        @(posedge clk);
        model_step(hv, hi, ha, ht, fl);
    endtask

    task automatic look(input logic [AW-1:0] fa, input string req);
        cyc(1'b0, 1'b0, '0, '0, 1'b0, fa, req);
    endtask

    task automatic hint(input bit imp, input logic [AW-1:0] ha, input logic [AW-1:0] ht, input string req);
        cyc(1'b1, imp, ha, ht, 1'b0, 32'hFFFF_0000, req);
    endtask

    function automatic logic [AW-1:0] pool(input int k);
        return 32'h0000_1000 + 32'(k) * 32'h10;
    endfunction

    initial begin
        model_clear();
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: empty after reset
        look(pool(0), "R1");
        look(32'h0, "R1");

        // R2: allocate then hit
        hint(1'b1, pool(0), 32'hA000_0000, "R2");
        look(pool(0), "R2");
        // R9: hint and lookup of the same address in one cycle sees the old contents
        cyc(1'b1, 1'b1, pool(1), 32'hA000_0010, 1'b0, pool(1), "R9");
        look(pool(1), "R9");
        // R3: unflagged hint to a new address and to a stored address
        hint(1'b0, pool(2), 32'hBAD0_0000, "R3");
        look(pool(2), "R3");
        hint(1'b0, pool(0), 32'hBAD0_0001, "R3");
        look(pool(0), "R3");
        // R6: fill the remaining slots
        hint(1'b1, pool(2), 32'hA000_0020, "R6");
        hint(1'b1, pool(3), 32'hA000_0030, "R6");
        for (int k = 0; k < 4; k++) look(pool(k), "R6");
        // R5: in-place update on a full table keeps every other entry
        hint(1'b1, pool(1), 32'hC000_0011, "R5");
        for (int k = 0; k < 4; k++) look(pool(k), "R5");
        // R7: round-robin replacement 0,1,2,3,0
        for (int k = 4; k < 9; k++) begin
            hint(1'b1, pool(k), 32'hD000_0000 + 32'(k), "R7");
            for (int j = 0; j < 9; j++) look(pool(j), "R7");
        end
        // R8: flush wins over a simultaneous hint
        cyc(1'b1, 1'b1, pool(20), 32'hE000_0000, 1'b1, pool(8), "R8");
        look(pool(20), "R8");
        look(pool(8), "R8");
        hint(1'b1, pool(21), 32'hE000_0001, "R8");
        look(pool(21), "R8");
        // R4/R10: seeded random traffic
        for (int t = 0; t < 3000; t++) begin
            cyc(($urandom % 2) == 0, ($urandom % 4) != 0, pool($urandom % 8), $urandom,
                ($urandom % 64) == 0, pool($urandom % 8), "R4/R10");
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule